// File: doc/BRIEF.md
# Branch Mispredict Squash Controller

This block controls squashing and fetch redirection for a scalar six-stage pipeline: fetch (F), decode (D), issue (I), execute-0 (X0), execute-1 (X1) and writeback (W). It holds one small control record per stage: a valid bit, a delay-slot tag and a branch flag. Every cycle these records move one stage along. A branch resolves at the end of X1. The instruction that immediately follows a branch is its delay slot, and that instruction always executes.

When the branch in X1 turns out to be mispredicted, the block kills every younger valid instruction in F, D, I and X0 except the delay slot. The delay slot is spared in whichever stage it currently sits. The block then loads the fetch PC with the corrected target. If an instruction-cache miss has kept the delay slot from arriving, the redirect is held back. The next instruction that fetch delivers is accepted as the delay slot, and only then is the PC redirected.

Top module: `squash_ctrl`

## Requirements
- R1: Each clock edge moves every stage record one stage toward W. An instruction presented with `fetch_vld_i` high enters F. When `fetch_vld_i` is low, a bubble enters F.
- R2: The first instruction delivered after a branch is tagged as a delay slot. A tagged instruction is never recorded as a branch, even if `fetch_is_br_i` is high.
- R3: A mispredict is a high `mispredict_i` while X1 holds a valid branch. On a mispredict, each killed stage among F, D, I and X0 becomes a bubble at the next edge. `kill_o` bit 0 is F, bit 1 is D, bit 2 is I and bit 3 is X0. It reports the killed stages for exactly the cycle after that edge.
- R4: On a mispredict, the oldest valid delay-slot-tagged instruction in X0, I, D or F (searched in that order) is not killed. Every other valid instruction in those stages is killed.
- R5: At most three stages are killed by one mispredict.
- R6: If the delay slot is in the pipeline, or is delivered in the mispredict cycle, then after that edge `fetch_pc_o` equals `target_i` and `redirect_o` is high for one cycle. An instruction delivered in that cycle is kept only if it is the delay slot.
- R7: If the delay slot has not arrived and fetch delivers nothing in the mispredict cycle, the block waits. While it waits, `fetch_pc_o` holds and `redirect_o` stays low. The next delivered instruction enters F tagged as the delay slot. At that edge `fetch_pc_o` becomes the saved target and `redirect_o` pulses.
- R8: With no mispredict and no pending redirect, `fetch_pc_o` advances by `STEP` for each delivered instruction and holds otherwise.
- R9: `mispredict_i` has no effect unless X1 holds a valid branch.
- R10: After reset, all stage records are invalid, `kill_o` and `redirect_o` are low, and `fetch_pc_o` equals `RESET_PC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld_i | input | 1 | Fetch delivers an instruction this cycle |
| fetch_is_br_i | input | 1 | The delivered instruction is a branch |
| mispredict_i | input | 1 | The branch in X1 was mispredicted |
| target_i | input | PC_W | Corrected fetch address for the branch in X1 |
| fetch_pc_o | output | PC_W | Current fetch address |
| redirect_o | output | 1 | Fetch address was loaded with a corrected target at the last edge |
| kill_o | output | 4 | Stages F, D, I, X0 killed at the last edge (bit 0 = F) |
| stage_vld_o | output | 6 | Valid bit per stage, bit 0 = F to bit 5 = W |
| stage_ds_o | output | 6 | Delay-slot tag per stage, bit 0 = F to bit 5 = W |

## Verification
A wrong delay-slot tag or a lost branch flag stays hidden until a mispredict. At that edge it shows up as a killed delay slot, or as a surviving wrong-path instruction in `stage_vld_o`. A corrupted pending flag or saved target shows up at the first fetch after the miss, as a missing `redirect_o` pulse or a wrong `fetch_pc_o`. The bench places the delay slot in every young stage, at the fetch input, and several cycles behind a miss, with varied bubble fills. It compares all outputs with its model on every cycle, so any such error is reported in the cycle it surfaces.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int N_STG = 6;
  localparam int N_YNG = 4;

  typedef enum int {
    ST_F  = 0,
    ST_D  = 1,
    ST_I  = 2,
    ST_X0 = 3,
    ST_X1 = 4,
    ST_W  = 5
  } stage_e;

  typedef struct packed {
    logic vld;
    logic ds;
    logic br;
  } stg_t;
endpackage

// File: rtl/sq_stage_pipe.sv
module sq_stage_pipe
  import sq_pkg::*;
#(
  parameter int NS = N_STG,
  parameter int NY = N_YNG
) (
  input  logic              clk,
  input  logic              rst,
  input  stg_t              in_stg,
  input  logic [NY-1:0]     kill,
  output stg_t [NS-1:0]     stg_q
);
  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= in_stg;
  end

  for (genvar k = 1; k < NS; k++) begin : g_stage
    if (k - 1 < NY) begin : g_killable
      always_ff @(posedge clk) begin
        if (rst || kill[k-1]) stg_q[k] <= '0;
        else                  stg_q[k] <= stg_q[k-1];
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) stg_q[k] <= '0;
        else     stg_q[k] <= stg_q[k-1];
      end
    end
  end
endmodule

// File: rtl/sq_kill_sel.sv
module sq_kill_sel
  import sq_pkg::*;
#(
  parameter int NS = N_STG,
  parameter int NY = N_YNG
) (
  input  stg_t [NS-1:0] stg,
  input  logic          fire,
  output logic [NY-1:0] kill,
  output logic          ds_here
);
  logic found;

  // scan from the oldest young stage toward F; spare the first tagged one
  always_comb begin
    found = 1'b0;
    kill  = '0;
    for (int k = NY - 1; k >= 0; k--) begin
      if (stg[k].vld) begin
        if (stg[k].ds && !found) found = 1'b1;
        else                     kill[k] = fire;
      end
    end
    ds_here = found;
  end
endmodule

// File: rtl/sq_fetch_ctrl.sv
module sq_fetch_ctrl
  import sq_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              STEP     = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_vld,
  input  logic            fetch_br,
  input  logic            fire,
  input  logic            ds_here,
  input  logic [PC_W-1:0] target,
  output stg_t            in_stg,
  output logic [PC_W-1:0] pc_q,
  output logic            redir_q,
  output logic            pend_q
);
  localparam logic [PC_W-1:0] INC = PC_W'(STEP);

  logic            owed_q, owed_n, pend_n, redir_n, take, in_ds;
  logic [PC_W-1:0] tgt_q, tgt_n, pc_n;

  always_comb begin
    in_ds   = fetch_vld & owed_q;
    take    = fetch_vld;
    pc_n    = pc_q;
    redir_n = 1'b0;
    owed_n  = owed_q;
    pend_n  = pend_q;
    tgt_n   = tgt_q;
    if (fire) begin
      if (ds_here) begin
        take    = 1'b0;
        pc_n    = target;
        redir_n = 1'b1;
        owed_n  = 1'b0;
      end else if (fetch_vld) begin
        pc_n    = target;
        redir_n = 1'b1;
        owed_n  = 1'b0;
      end else begin
        pend_n  = 1'b1;
        tgt_n   = target;
      end
    end else if (pend_q && fetch_vld) begin
      pc_n    = tgt_q;
      redir_n = 1'b1;
      pend_n  = 1'b0;
      owed_n  = 1'b0;
    end else if (fetch_vld) begin
      pc_n    = pc_q + INC;
      owed_n  = fetch_br & ~in_ds;
    end
    in_stg.vld = take;
    in_stg.ds  = take & in_ds;
    in_stg.br  = take & fetch_br & ~in_ds;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_PC;
      redir_q <= 1'b0;
      owed_q  <= 1'b0;
      pend_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      pc_q    <= pc_n;
      redir_q <= redir_n;
      owed_q  <= owed_n;
      pend_q  <= pend_n;
      tgt_q   <= tgt_n;
    end
  end
endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl
  import sq_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              STEP     = 4,
  parameter logic [PC_W-1:0] RESET_PC = 'h100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_vld_i,
  input  logic                fetch_is_br_i,
  input  logic                mispredict_i,
  input  logic [PC_W-1:0]     target_i,
  output logic [PC_W-1:0]     fetch_pc_o,
  output logic                redirect_o,
  output logic [N_YNG-1:0]    kill_o,
  output logic [N_STG-1:0]    stage_vld_o,
  output logic [N_STG-1:0]    stage_ds_o
);
  stg_t [N_STG-1:0] stg_q;
  stg_t             in_stg;
  logic [N_YNG-1:0] kill_c;
  logic             ds_here_c, fire_c, x1_br_c, pend_c;

  assign x1_br_c = stg_q[ST_X1].vld & stg_q[ST_X1].br;
  assign fire_c  = x1_br_c & mispredict_i;

  sq_kill_sel #(.NS(N_STG), .NY(N_YNG)) u_sel (
    .stg(stg_q), .fire(fire_c), .kill(kill_c), .ds_here(ds_here_c)
  );

  sq_fetch_ctrl #(.PC_W(PC_W), .STEP(STEP), .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld_i), .fetch_br(fetch_is_br_i),
    .fire(fire_c), .ds_here(ds_here_c), .target(target_i), .in_stg(in_stg),
    .pc_q(fetch_pc_o), .redir_q(redirect_o), .pend_q(pend_c)
  );

  sq_stage_pipe #(.NS(N_STG), .NY(N_YNG)) u_pipe (
    .clk(clk), .rst(rst), .in_stg(in_stg), .kill(kill_c), .stg_q(stg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) kill_o <= '0;
    else     kill_o <= kill_c;
  end

  for (genvar k = 0; k < N_STG; k++) begin : g_out
    assign stage_vld_o[k] = stg_q[k].vld;
    assign stage_ds_o[k]  = stg_q[k].ds;
  end
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_vld_i,
  input logic            mispredict_i,
  input logic [PC_W-1:0] target_i,
  input logic [PC_W-1:0] fetch_pc_o,
  input logic            redirect_o,
  input logic [3:0]      kill_o,
  input logic [5:0]      stage_vld_o,
  input logic [5:0]      stage_ds_o,
  input logic            fire_c,
  input logic            x1_br_c,
  input logic            pend_c,
  input logic            ds_here_c
);
  assert_kill_cap_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(kill_o) <= 3);

  assert_killed_bubble_R3: assert property (@(posedge clk) disable iff (rst)
    (kill_o & stage_vld_o[4:1]) == 4'b0000);

  assert_spurious_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (mispredict_i && !x1_br_c) |=> (kill_o == 4'b0000));

  assert_pend_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_c && !fetch_vld_i) |=> ($stable(fetch_pc_o) && !redirect_o));

  assert_pend_release_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_c && fetch_vld_i) |=> (redirect_o && stage_vld_o[0] && stage_ds_o[0]));

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!pend_c && !fire_c && fetch_vld_i) |=>
      ((fetch_pc_o == $past(fetch_pc_o) + PC_W'(STEP)) && !redirect_o));

  assert_fire_redirect_R6: assert property (@(posedge clk) disable iff (rst)
    (fire_c && (ds_here_c || fetch_vld_i)) |=>
      (redirect_o && fetch_pc_o == $past(target_i)));
endmodule

bind squash_ctrl sq_checker #(.PC_W(PC_W), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .fetch_vld_i(fetch_vld_i), .mispredict_i(mispredict_i),
  .target_i(target_i), .fetch_pc_o(fetch_pc_o), .redirect_o(redirect_o),
  .kill_o(kill_o), .stage_vld_o(stage_vld_o), .stage_ds_o(stage_ds_o),
  .fire_c(fire_c), .x1_br_c(x1_br_c), .pend_c(pend_c), .ds_here_c(ds_here_c)
);

// File: tb/squash_ctrl_tb.sv
module squash_ctrl_tb;
  localparam logic [31:0] RPC = 32'h100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_vld_i = 1'b0, fetch_is_br_i = 1'b0, mispredict_i = 1'b0;
  logic [31:0] target_i = '0;
  logic [31:0] fetch_pc_o;
  logic        redirect_o;
  logic [3:0]  kill_o;
  logic [5:0]  stage_vld_o, stage_ds_o;

  always #5 clk = ~clk;

  squash_ctrl #(.PC_W(32), .STEP(4), .RESET_PC(RPC)) u_dut (
    .clk(clk), .rst(rst), .fetch_vld_i(fetch_vld_i), .fetch_is_br_i(fetch_is_br_i),
    .mispredict_i(mispredict_i), .target_i(target_i), .fetch_pc_o(fetch_pc_o),
    .redirect_o(redirect_o), .kill_o(kill_o), .stage_vld_o(stage_vld_o),
    .stage_ds_o(stage_ds_o)
  );

  // behavioural model: instruction ids per stage, attributes by id
  int          mst[6];
  bit          m_ds[int];
  bit          m_br[int];
  int          next_id;
  logic [31:0] m_pc, m_ptgt;
  bit          m_owed, m_pend, m_redir;
  logic [3:0]  m_kill;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(bit fv, bit fbr, bit mp, logic [31:0] tgt);
    bit fire, accept, isds;
    int keep, nid;
    logic [3:0] kv;
    fire = (mst[4] >= 0) && m_br[mst[4]] && mp;
    keep = -1;
    kv = '0;
    m_redir = 1'b0;
    if (fire) begin
      for (int k = 3; k >= 0; k--)
        if (keep < 0 && mst[k] >= 0 && m_ds[mst[k]]) keep = k;
      for (int k = 0; k < 4; k++)
        if (mst[k] >= 0 && k != keep) kv[k] = 1'b1;
    end
    isds = fv && m_owed;
    nid = next_id;
    accept = fv;
    if (fire) begin
      if (keep >= 0) begin
        accept = 1'b0; m_pc = tgt; m_redir = 1'b1; m_owed = 1'b0;
      end else if (fv) begin
        m_pc = tgt; m_redir = 1'b1; m_owed = 1'b0;
      end else begin
        m_pend = 1'b1; m_ptgt = tgt;
      end
    end else if (m_pend && fv) begin
      m_pc = m_ptgt; m_redir = 1'b1; m_pend = 1'b0; m_owed = 1'b0;
    end else if (fv) begin
      m_pc = m_pc + 32'd4;
      m_owed = fbr && !isds;
    end
    if (accept) begin
      next_id++;
      m_ds[nid] = isds;
      m_br[nid] = fbr && !isds;
    end
    for (int k = 5; k >= 1; k--)
      mst[k] = (k - 1 <= 3 && kv[k-1]) ? -1 : mst[k-1];
    mst[0] = accept ? nid : -1;
    m_kill = kv;
  endtask

  task automatic compare_all();
    logic [5:0] ev, ed;
    for (int k = 0; k < 6; k++) begin
      ev[k] = mst[k] >= 0;
      ed[k] = (mst[k] >= 0) && m_ds[mst[k]];
    end
    chk("R1 R3 stage valid", 64'(stage_vld_o), 64'(ev));
    chk("R2 R4 delay-slot tags", 64'(stage_ds_o), 64'(ed));
    chk("R3 R4 R5 kill mask", 64'(kill_o), 64'(m_kill));
    chk("R6 R7 redirect pulse", 64'(redirect_o), 64'(m_redir));
    chk("R6 R7 R8 fetch pc", 64'(fetch_pc_o), 64'(m_pc));
  endtask

  task automatic cyc(bit fv, bit fbr, bit mp, logic [31:0] tgt);
    fetch_vld_i = fv; fetch_is_br_i = fbr; mispredict_i = mp; target_i = tgt;
    model_step(fv, fbr, mp, tgt);
    @(negedge clk);
    compare_all();
  endtask

  // delay slot arrives gap bubbles after its branch; fill sets later fetches
  task automatic run_gap(int gap, int fill);
    int  brid, waited;
    bit  ds_done, fv, mp;
    logic [31:0] t;
    repeat (6) cyc(1'b0, 1'b0, 1'b0, '0);
    brid = next_id;
    cyc(1'b1, 1'b1, 1'b0, '0);
    waited = 0;
    ds_done = 1'b0;
    for (int c = 0; c < 18; c++) begin
      if (!ds_done) begin
        fv = (waited == gap);
        if (fv) ds_done = 1'b1; else waited++;
      end else begin
        case (fill)
          0:       fv = 1'b1;
          1:       fv = 1'b0;
          default: fv = 1'($urandom_range(0, 1));
        endcase
      end
      mp = (mst[4] == brid);
      t = 32'h1000 + 32'($urandom_range(0, 255)) * 32'd4;
      cyc(fv, 1'b0, mp, t);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) mst[k] = -1;
    next_id = 0;
    m_pc = RPC; m_ptgt = '0; m_owed = 0; m_pend = 0; m_redir = 0; m_kill = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset valid", 64'(stage_vld_o), 64'd0);
    chk("R10 reset kill", 64'(kill_o), 64'd0);
    chk("R10 reset redirect", 64'(redirect_o), 64'd0);
    chk("R10 reset pc", 64'(fetch_pc_o), 64'(RPC));
    rst = 1'b0;
    // R4 R6 R7: delay slot in X0, I, D, F, at fetch input, then pending
    for (int gap = 0; gap < 8; gap++)
      for (int fill = 0; fill < 4; fill++)
        run_gap(gap, fill);
    // random mix with branches, bubbles and spurious mispredicts (R9)
    for (int c = 0; c < 800; c++) begin
      bit fv, fbr, mp, x1b, spur;
      fv  = $urandom_range(0, 9) < 7;
      fbr = $urandom_range(0, 3) == 0;
      x1b = (mst[4] >= 0) && m_br[mst[4]];
      mp  = x1b ? 1'($urandom_range(0, 1)) : ($urandom_range(0, 9) == 0);
      spur = mp && !x1b;
      cyc(fv, fbr, mp, 32'h2000 + 32'($urandom_range(0, 511)) * 32'd4);
      if (spur) chk("R9 spurious mispredict ignored", 64'(kill_o), 64'd0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule